// File: doc/BRIEF.md
# Multi-Set Message Interrupt Capture Controller

This block turns inbound memory-write messages into one level interrupt request. Its vectors are split into groups. Each group answers at one programmable 64-bit message address. When a write hits that address, the write data picks which pending bit in the group to set. Each group also has a per-vector mask, and any pending bit whose mask bit is set raises a summary line for the group. A top-level enable/status pair gathers the group summaries and four legacy level interrupt lines, and drives a single registered interrupt output.

Software programs the message addresses, masks and enables through a simple register port. It services an interrupt in three steps: read the top status, read the pending word of the group, then clear the handled bits by writing ones. The message port uses valid/ready. Ready is held high, so the block never applies back-pressure and takes one message on every cycle in which valid is high. Each message is dealt with in full on the clock edge that accepts it.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, irq_out is 0, and every pending word and the top status register read as 0.
- R2: For group g, the low half of the message address is read/write at byte offset 0xC00+16·g. The high half is read/write at 0xC80+4·g. The group-on register at 0x190 holds bit g to accept messages for group g.
- R3: A message accepted while group g is on, with an address equal to {high,low} of group g and data below 32, sets pending bit data of group g. The pending word is at 0xC04+16·g. The bit is set on the accepting edge whether or not its mask bit is set.
- R4: A message whose data is 32 or more sets no pending bit.
- R5: A message whose address matches no group that is on sets no pending bit.
- R6: Writing the pending word clears every bit written as 1 and leaves bits written as 0 unchanged.
- R7: If a message sets a bit on the same edge that a write clears that bit, the bit stays set. Other bits in the same clear are still removed.
- R8: Group g's summary is the OR of its pending word ANDed with its mask word (at 0xC08+16·g). While the summary is high, top status bit 8+g (register 0x184) is set.
- R9: Writing 1 to a top status bit clears it, but it is set again on the same edge while its source is still active.
- R10: While legacy line i is high, top status bit 24+i is set.
- R11: irq_out is registered. It goes high one edge after any top status bit is set together with its enable bit in 0x180, which uses the same bit layout. A message therefore raises irq_out two edges after it is accepted.
- R12: With a top enable bit at 0, its status bit still records the event but does not raise irq_out.
- R13: msg_ready is always 1, so every message with valid high is consumed on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after cfg_rd |
| msg_valid | input | 1 | Inbound message present |
| msg_ready | output | 1 | Always high, no back-pressure |
| msg_addr | input | 64 | Message target address |
| msg_data | input | 32 | Message data, vector index |
| intx_in | input | 4 | Legacy level interrupt lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A message accepted at edge E sets the pending bit at E. The top status bit follows at E+1, and irq_out rises at E+2. A legacy line sampled high at edge E sets its status bit at E and irq_out at E+1. Register reads return the value held before the read edge. The bench therefore samples at the falling edge after the exact edge on which a result is due, and checks the intermediate edges where the output must still be low. Clears and collisions are driven together on one edge and checked with a read on a later edge.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned RA_W = 12;
  localparam int unsigned DW = 32;
  localparam logic [RA_W-1:0] LO_BASE = 12'hC00;
  localparam int unsigned GRP_STRIDE = 16;
  localparam int unsigned PEND_OFS = 4;
  localparam int unsigned MASK_OFS = 8;
  localparam logic [RA_W-1:0] HI_BASE = 12'hC80;
  localparam int unsigned HI_STRIDE = 4;
  localparam logic [RA_W-1:0] GRP_ON_ADDR = 12'h190;
  localparam logic [RA_W-1:0] TOP_EN_ADDR = 12'h180;
  localparam logic [RA_W-1:0] TOP_ST_ADDR = 12'h184;
  localparam int unsigned SUM_LSB = 8;
  localparam int unsigned LEG_LSB = 24;

  typedef struct packed {
    logic            we;
    logic [RA_W-1:0] addr;
    logic [DW-1:0]   wdata;
  } cfg_wr_t;

  function automatic logic [RA_W-1:0] lo_addr(input int idx);
    return LO_BASE + RA_W'(idx * GRP_STRIDE);
  endfunction
  function automatic logic [RA_W-1:0] pend_addr(input int idx);
    return lo_addr(idx) + RA_W'(PEND_OFS);
  endfunction
  function automatic logic [RA_W-1:0] mask_addr(input int idx);
    return lo_addr(idx) + RA_W'(MASK_OFS);
  endfunction
  function automatic logic [RA_W-1:0] hi_addr(input int idx);
    return HI_BASE + RA_W'(idx * HI_STRIDE);
  endfunction
endpackage

// File: rtl/msi_group_unit.sv
module msi_group_unit
  import msi_cap_pkg::*;
#(
  parameter int IDX  = 0,
  parameter int VECS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_wr_t           wr,
  input  logic              grp_on,
  input  logic              msg_fire,
  input  logic [2*DW-1:0]   msg_addr,
  input  logic [DW-1:0]     msg_data,
  output logic [DW-1:0]     lo_q,
  output logic [DW-1:0]     hi_q,
  output logic [VECS-1:0]   pend_q,
  output logic [VECS-1:0]   mask_q,
  output logic              summary
);
  localparam int IW = $clog2(VECS);
  localparam logic [RA_W-1:0] A_LO = lo_addr(IDX);
  localparam logic [RA_W-1:0] A_HI = hi_addr(IDX);
  localparam logic [RA_W-1:0] A_PD = pend_addr(IDX);
  localparam logic [RA_W-1:0] A_MK = mask_addr(IDX);

  logic            hit;
  logic [VECS-1:0] set_vec, clr_vec;

  assign hit     = msg_fire && grp_on && (msg_addr == {hi_q, lo_q})
                   && (msg_data < DW'(VECS));
  assign set_vec = hit ? (VECS'(1) << msg_data[IW-1:0]) : '0;
  assign clr_vec = (wr.we && wr.addr == A_PD) ? wr.wdata[VECS-1:0] : '0;
  assign summary = |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr.we && wr.addr == A_LO) lo_q <= wr.wdata;
      if (wr.we && wr.addr == A_HI) hi_q <= wr.wdata;
      if (wr.we && wr.addr == A_MK) mask_q <= wr.wdata[VECS-1:0];
      pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
  end
endmodule

// File: rtl/msi_top_regs.sv
module msi_top_regs
  import msi_cap_pkg::*;
#(
  parameter int NGRP = 8,
  parameter int NLEG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_wr_t         wr,
  input  logic [NGRP-1:0] summ,
  input  logic [NLEG-1:0] leg,
  output logic [NGRP-1:0] grp_on,
  output logic [NGRP-1:0] sum_en,
  output logic [NLEG-1:0] leg_en,
  output logic [NGRP-1:0] sum_st,
  output logic [NLEG-1:0] leg_st,
  output logic            irq
);
  logic st_wr;
  logic [NGRP-1:0] sum_clr;
  logic [NLEG-1:0] leg_clr;

  assign st_wr   = wr.we && wr.addr == TOP_ST_ADDR;
  assign sum_clr = st_wr ? wr.wdata[SUM_LSB +: NGRP] : '0;
  assign leg_clr = st_wr ? wr.wdata[LEG_LSB +: NLEG] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_on <= '0;
      sum_en <= '0;
      leg_en <= '0;
      sum_st <= '0;
      leg_st <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr.we && wr.addr == GRP_ON_ADDR) grp_on <= wr.wdata[NGRP-1:0];
      if (wr.we && wr.addr == TOP_EN_ADDR) begin
        sum_en <= wr.wdata[SUM_LSB +: NGRP];
        leg_en <= wr.wdata[LEG_LSB +: NLEG];
      end
      sum_st <= (sum_st & ~sum_clr) | summ;
      leg_st <= (leg_st & ~leg_clr) | leg;
      irq    <= (|(sum_st & sum_en)) | (|(leg_st & leg_en));
    end
  end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int NUM_SETS    = 8,
  parameter int VEC_PER_SET = 32,
  parameter int NUM_LEG     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [2*DW-1:0]   msg_addr,
  input  logic [DW-1:0]     msg_data,
  input  logic [NUM_LEG-1:0] intx_in,
  output logic              irq_out
);
  cfg_wr_t wr;
  logic    msg_fire;
  logic [NUM_SETS-1:0][DW-1:0]          lo_all, hi_all;
  logic [NUM_SETS-1:0][VEC_PER_SET-1:0] pend_all, mask_all;
  logic [NUM_SETS-1:0] summ, grp_on, sum_en, sum_st;
  logic [NUM_LEG-1:0]  leg_en, leg_st;
  logic [DW-1:0]       rd_mux;

  assign wr        = '{we: cfg_wr, addr: cfg_addr, wdata: cfg_wdata};
  assign msg_ready = 1'b1;
  assign msg_fire  = msg_valid && msg_ready;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_grp
    msi_group_unit #(.IDX(g), .VECS(VEC_PER_SET)) u_grp (
      .clk, .rst_n, .wr, .grp_on(grp_on[g]), .msg_fire, .msg_addr, .msg_data,
      .lo_q(lo_all[g]), .hi_q(hi_all[g]), .pend_q(pend_all[g]),
      .mask_q(mask_all[g]), .summary(summ[g])
    );
  end

  msi_top_regs #(.NGRP(NUM_SETS), .NLEG(NUM_LEG)) u_top (
    .clk, .rst_n, .wr, .summ, .leg(intx_in), .grp_on, .sum_en, .leg_en,
    .sum_st, .leg_st, .irq(irq_out)
  );

  always_comb begin
    rd_mux = '0;
    if (cfg_addr == GRP_ON_ADDR) rd_mux[NUM_SETS-1:0] = grp_on;
    if (cfg_addr == TOP_EN_ADDR) begin
      rd_mux[SUM_LSB +: NUM_SETS] = sum_en;
      rd_mux[LEG_LSB +: NUM_LEG]  = leg_en;
    end
    if (cfg_addr == TOP_ST_ADDR) begin
      rd_mux[SUM_LSB +: NUM_SETS] = sum_st;
      rd_mux[LEG_LSB +: NUM_LEG]  = leg_st;
    end
    for (int s = 0; s < NUM_SETS; s++) begin
      if (cfg_addr == lo_addr(s))   rd_mux = lo_all[s];
      if (cfg_addr == hi_addr(s))   rd_mux = hi_all[s];
      if (cfg_addr == pend_addr(s)) rd_mux[VEC_PER_SET-1:0] = pend_all[s];
      if (cfg_addr == mask_addr(s)) rd_mux[VEC_PER_SET-1:0] = mask_all[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk
  import msi_cap_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int VEC      = 32,
  parameter int NUM_LEG  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic msg_valid,
  input logic [2*DW-1:0] msg_addr,
  input logic [DW-1:0] msg_data,
  input logic [NUM_LEG-1:0] intx_in,
  input logic irq_out,
  input logic [NUM_SETS-1:0] grp_on,
  input logic [NUM_SETS-1:0][DW-1:0] lo_all,
  input logic [NUM_SETS-1:0][DW-1:0] hi_all,
  input logic [NUM_SETS-1:0][VEC-1:0] pend_all,
  input logic [NUM_SETS-1:0] summ,
  input logic [NUM_SETS-1:0] sum_st,
  input logic [NUM_SETS-1:0] sum_en,
  input logic [NUM_LEG-1:0] leg_st,
  input logic [NUM_LEG-1:0] leg_en
);
  localparam int IW = $clog2(VEC);
  logic any_match;
  always_comb begin
    any_match = 1'b0;
    for (int s = 0; s < NUM_SETS; s++)
      if (grp_on[s] && msg_addr == {hi_all[s], lo_all[s]}) any_match = 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq_out);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_cap
    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && grp_on[s] && msg_addr == {hi_all[s], lo_all[s]} && msg_data < DW'(VEC))
      |=> pend_all[s][$past(msg_data[IW-1:0])]);
    // R8
    summary_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      summ[s] |=> sum_st[s]);
  end

  // R4
  big_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_data >= DW'(VEC) || !msg_valid) |=> ((pend_all & ~$past(pend_all)) == '0));

  // R5
  no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_match) |=> ((pend_all & ~$past(pend_all)) == '0));

  for (genvar i = 0; i < NUM_LEG; i++) begin : g_leg
    // R10
    legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intx_in[i] |=> leg_st[i]);
  end

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(sum_st & sum_en)) || (|(leg_st & leg_en))) |=> irq_out);
endmodule

bind msi_capture_ctrl msi_capture_chk #(
  .NUM_SETS(NUM_SETS), .VEC(VEC_PER_SET), .NUM_LEG(NUM_LEG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
  .msg_data(msg_data), .intx_in(intx_in), .irq_out(irq_out), .grp_on(grp_on),
  .lo_all(lo_all), .hi_all(hi_all), .pend_all(pend_all), .summ(summ),
  .sum_st(sum_st), .sum_en(sum_en), .leg_st(leg_st), .leg_en(leg_en)
);

// File: tb/msi_capture_ctrl_test.sv
`timescale 1ns/1ps
module msi_capture_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_rd = 0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic msg_valid = 0, msg_ready;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic [3:0] intx_in = '0;
  logic irq_out;
  int total = 0, bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  msi_capture_ctrl uut (.*);

  // {group[15:13], miss[12], expect[11], 3'b0, data[7:0]}
  localparam logic [15:0] TBL [8] = '{
    {3'd0, 1'b0, 1'b1, 3'b0, 8'd0},
    {3'd1, 1'b0, 1'b1, 3'b0, 8'd31},
    {3'd2, 1'b0, 1'b0, 3'b0, 8'd32},
    {3'd3, 1'b0, 1'b0, 3'b0, 8'd200},
    {3'd4, 1'b1, 1'b0, 3'b0, 8'd5},
    {3'd5, 1'b0, 1'b1, 3'b0, 8'd17},
    {3'd6, 1'b0, 1'b0, 3'b0, 8'd3},
    {3'd7, 1'b0, 1'b1, 3'b0, 8'd9}
  };

  function automatic logic [31:0] lo_of(input int s); return 32'h8000_0000 + 32'(s) * 32'h1000; endfunction
  function automatic logic [31:0] hi_of(input int s); return 32'h10 + 32'(s); endfunction
  function automatic logic [63:0] ga(input int s); return {hi_of(s), lo_of(s)}; endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk) cfg_wr = 0;
  endtask
  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); cfg_rd = 1; cfg_addr = a;
    @(posedge clk); @(negedge clk) cfg_rd = 0; d = cfg_rdata;
  endtask
  task automatic send(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); msg_valid = 1; msg_addr = a; msg_data = d;
    @(posedge clk); @(negedge clk) msg_valid = 0;
  endtask
  task automatic finish_run();
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++; $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    chk(irq_out == 0, "R1 irq after reset", 32'(irq_out), 0);
    chk(msg_ready == 1, "R13 ready", 32'(msg_ready), 1);
    rd_reg(12'h184, rv); chk(rv == 0, "R1 top status", rv, 0);
    rd_reg(12'hC24, rv); chk(rv == 0, "R1 pending", rv, 0);

    for (int s = 0; s < 8; s++) begin
      wr_reg(12'hC00 + 12'(s * 16), lo_of(s));
      wr_reg(12'hC80 + 12'(s * 4), hi_of(s));
    end
    wr_reg(12'h190, 32'hBF);
    rd_reg(12'hC30, rv); chk(rv == lo_of(3), "R2 low addr", rv, lo_of(3));
    rd_reg(12'hC8C, rv); chk(rv == hi_of(3), "R2 high addr", rv, hi_of(3));
    rd_reg(12'h190, rv); chk(rv == 32'hBF, "R2 group on", rv, 32'hBF);

    // table walk: R3 hits, R4 large data, R5 miss and disabled group
    for (int i = 0; i < 8; i++) begin
      int s; logic [31:0] ex;
      s = int'(TBL[i][15:13]);
      ex = TBL[i][11] ? (32'd1 << TBL[i][4:0]) : 32'd0;
      send(TBL[i][12] ? ga(s) + 64'd4 : ga(s), {24'd0, TBL[i][7:0]});
      rd_reg(12'hC04 + 12'(s * 16), rv);
      chk(rv == ex, TBL[i][11] ? "R3 capture" : "R4/R5 discard", rv, ex);
      wr_reg(12'hC04 + 12'(s * 16), 32'hFFFF_FFFF);
    end
    chk(msg_ready == 1, "R13 ready mid-run", 32'(msg_ready), 1);

    // R6 and R7 on group 1
    send(ga(1), 6); send(ga(1), 7);
    wr_reg(12'hC14, 32'h0);
    rd_reg(12'hC14, rv); chk(rv == 32'hC0, "R6 zero write", rv, 32'hC0);
    @(negedge clk); cfg_wr = 1; cfg_addr = 12'hC14; cfg_wdata = 32'hC0;
    msg_valid = 1; msg_addr = ga(1); msg_data = 7;
    @(posedge clk); @(negedge clk) begin cfg_wr = 0; msg_valid = 0; end
    rd_reg(12'hC14, rv); chk(rv == 32'h80, "R7 collision", rv, 32'h80);
    wr_reg(12'hC14, 32'h80);
    rd_reg(12'hC14, rv); chk(rv == 0, "R6 clear", rv, 0);

    // R8 / R11 on group 2
    wr_reg(12'h180, 32'h0F00_FF00);
    wr_reg(12'hC28, 32'h8);
    send(ga(2), 4);
    repeat (3) @(posedge clk);
    @(negedge clk) chk(irq_out == 0, "R8 masked vector irq", 32'(irq_out), 0);
    rd_reg(12'h184, rv); chk(rv == 0, "R8 masked vector status", rv, 0);
    send(ga(2), 3);
    chk(irq_out == 0, "R11 irq at E", 32'(irq_out), 0);
    @(posedge clk); @(negedge clk) chk(irq_out == 0, "R11 irq at E+1", 32'(irq_out), 0);
    @(posedge clk); @(negedge clk) chk(irq_out == 1, "R11 irq at E+2", 32'(irq_out), 1);
    rd_reg(12'h184, rv); chk(rv == 32'h400, "R8 summary bit", rv, 32'h400);

    // R9
    wr_reg(12'h184, 32'h400);
    rd_reg(12'h184, rv); chk(rv == 32'h400, "R9 source wins", rv, 32'h400);
    wr_reg(12'hC24, 32'hFFFF_FFFF);
    wr_reg(12'h184, 32'hFFFF_FFFF);
    rd_reg(12'h184, rv); chk(rv == 0, "R9 cleared", rv, 0);
    chk(irq_out == 0, "R9 irq drop", 32'(irq_out), 0);

    // R10
    @(negedge clk) intx_in = 4'b0100;
    @(posedge clk); @(posedge clk);
    @(negedge clk) chk(irq_out == 1, "R10 legacy irq", 32'(irq_out), 1);
    rd_reg(12'h184, rv); chk(rv == 32'h0400_0000, "R10 legacy status", rv, 32'h0400_0000);
    wr_reg(12'h184, 32'h0400_0000);
    rd_reg(12'h184, rv); chk(rv == 32'h0400_0000, "R10 held while high", rv, 32'h0400_0000);
    @(negedge clk) intx_in = 0;
    wr_reg(12'h184, 32'hFFFF_FFFF);
    rd_reg(12'h184, rv); chk(rv == 0, "R10 cleared", rv, 0);
    chk(irq_out == 0, "R10 irq low", 32'(irq_out), 0);

    // R12
    wr_reg(12'h180, 32'h0000_FF00);
    @(negedge clk) intx_in = 4'b1000;
    repeat (4) @(posedge clk);
    @(negedge clk) chk(irq_out == 0, "R12 gated irq", 32'(irq_out), 0);
    rd_reg(12'h184, rv); chk(rv == 32'h0800_0000, "R12 status kept", rv, 32'h0800_0000);
    rd_reg(12'h180, rv); chk(rv == 32'h0000_FF00, "R12 enable readback", rv, 32'h0000_FF00);
    @(negedge clk) intx_in = 0;

    finish_run();
  end
endmodule